// File: doc/BRIEF.md
# Random Word Delivery Front-End

This block sits between a random-bit generator and an instruction-level request port. The generator presents one 64-bit word per cycle with a valid strobe and a health-fail flag from its self-test. Words that passed the self-test go into a four-entry FIFO. Words that failed are thrown away at the FIFO input, and a sticky health-error flag records the event.

A request strobe is answered exactly one cycle later. If a stored word is on hand, the response carries the oldest stored word and a carry flag of 1. If the FIFO is empty because demand has outrun supply, the response carries an all-zero word and a carry flag of 0, and the requester is expected to retry. Data that failed the self-test can never reach the response port.

The block also presents a constant capability word that advertises the function in bit 30. It pulses a reseed request to the generator after a programmable number of generator words.

Top module: `rand_serve`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, rsp_valid, rsp_carry, rsp_data, health_err and reseed_req are all 0.
- R2: A request seen on a rising edge gives rsp_valid = 1 for exactly the following cycle. rsp_valid is never 1 without a request one cycle earlier.
- R3: If at least one word is stored when a request is sampled, the response has rsp_carry = 1 and rsp_data equal to the oldest stored word, and that word is removed. Words leave in the order they arrived.
- R4: If the FIFO is empty when a request is sampled, the response has rsp_carry = 0 and rsp_data is all zeros.
- R5: A generator word with gen_fail = 1 is never stored and never appears on rsp_data.
- R6: health_err goes to 1 on the cycle after gen_valid and gen_fail are sampled together, and stays at 1 until reset.
- R7: The FIFO holds at most 4 words. A valid, passing word that arrives while 4 words are stored and no word is removed in the same cycle is discarded.
- R8: A passing word that arrives in the same cycle as a request made while the FIFO is empty is not used for that request, which gets a no-data answer. The word is stored for a later request.
- R9: cap_word is constant: bit 30 is 1 and every other bit is 0.
- R10: reseed_req is 1 for one cycle, one cycle after the generator word (gen_valid = 1, with or without fail) that brings the count since reset or since the last pulse up to reseed_every. When reseed_every is 0, no pulse is given.
- R11: When the FIFO is full and a request removes a word, a passing word that arrives in the same cycle is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| gen_word | input | 64 | Word from the random-bit generator |
| gen_valid | input | 1 | gen_word is present this cycle |
| gen_fail | input | 1 | Self-test marks gen_word as bad |
| reseed_every | input | 16 | Number of generator words between reseed pulses; 0 disables them |
| req | input | 1 | Request strobe from the instruction port |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_carry | output | 1 | 1 = rsp_data is a valid random word, 0 = no data |
| rsp_data | output | 64 | Random word, or zero when there is no data |
| health_err | output | 1 | Sticky self-test failure flag |
| reseed_req | output | 1 | One-cycle reseed request pulse to the generator |
| cap_word | output | 32 | Capability word advertising the function in bit 30 |

## Verification
A wrong FIFO pointer or count shows up at the next request that hits the damaged entry, as a wrong word, as a carry flag of 1 where the bench expects no data, or the reverse. A cycle-accurate queue model in the bench catches it on that very response. A broken fail filter shows up as soon as a flagged word is requested, because every generator word is unique. Reseed-counter and sticky-flag faults show up on the cycle after the triggering generator word, because both outputs are compared on every cycle of a long pseudo-random sweep that covers every combination of valid, fail and request.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  localparam int unsigned WORD_W  = 64;
  localparam int unsigned CAP_W   = 32;
  localparam int unsigned CAP_BIT = 30;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/rsv_fifo.sv
module rsv_fifo #(
  parameter int unsigned DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  rsv_pkg::word_t  push_word,
  input  logic            pop,
  output rsv_pkg::word_t  head_word,
  output logic            empty,
  output logic            full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = AW + 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  rsv_pkg::word_t mem_q [DEPTH];
  logic [AW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    rd_d  = pop  ? bump(rd_q) : rd_q;
    wr_d  = push ? bump(wr_q) : wr_q;
    cnt_d = cnt_q;
    if (push && !pop) cnt_d = cnt_q + 1'b1;
    if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (push && (wr_q == AW'(g))) mem_q[g] <= push_word;
      end
    end
  endgenerate

  assign head_word = mem_q[rd_q];
  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == DEPTH_C);

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= DEPTH_C);
  a_r7_push_room: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |-> pop);
  a_r4_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop && empty));
endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_valid,
  input  logic             gen_fail,
  input  logic [CNT_W-1:0] interval,
  output logic             health_err,
  output logic             reseed_req
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   cnt_inc;
  logic             hit, err_q, err_d, pulse_q, pulse_d;

  always_comb begin
    cnt_inc = {1'b0, cnt_q} + 1'b1;
    hit     = gen_valid && (interval != '0) && (cnt_inc >= {1'b0, interval});
    cnt_d   = cnt_q;
    if (gen_valid) cnt_d = hit ? '0 : cnt_inc[CNT_W-1:0];
    pulse_d = hit;
    err_d   = err_q | (gen_valid & gen_fail);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      err_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      err_q   <= err_d;
      pulse_q <= pulse_d;
    end
  end

  assign health_err = err_q;
  assign reseed_req = pulse_q;

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    health_err |=> health_err);
  a_r6_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(health_err) |-> $past(gen_valid && gen_fail));
  a_r10_after_word: assert property (@(posedge clk) disable iff (!rst_n)
    reseed_req |-> $past(gen_valid));
endmodule

// File: rtl/rand_serve.sv
module rand_serve #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CNT_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [rsv_pkg::WORD_W-1:0]   gen_word,
  input  logic                         gen_valid,
  input  logic                         gen_fail,
  input  logic [CNT_W-1:0]             reseed_every,
  input  logic                         req,
  output logic                         rsp_valid,
  output logic                         rsp_carry,
  output logic [rsv_pkg::WORD_W-1:0]   rsp_data,
  output logic                         health_err,
  output logic                         reseed_req,
  output logic [rsv_pkg::CAP_W-1:0]    cap_word
);
  import rsv_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  word_t head;
  logic  empty, full, pop, push;
  logic  vld_q, vld_d, car_q, car_d;
  word_t dat_q, dat_d;

  always_comb begin
    pop   = req && !empty;
    push  = gen_valid && !gen_fail && (!full || pop);
    vld_d = req;
    car_d = pop;
    dat_d = pop ? head : '0;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      vld_q <= 1'b0;
      car_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= vld_d;
      car_q <= car_d;
      dat_q <= dat_d;
    end
  end

  rsv_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_i_n), .push(push), .push_word(gen_word),
    .pop(pop), .head_word(head), .empty(empty), .full(full)
  );

  rsv_monitor #(.CNT_W(CNT_W)) u_mon (
    .clk(clk), .rst_n(rst_i_n), .gen_valid(gen_valid), .gen_fail(gen_fail),
    .interval(reseed_every), .health_err(health_err), .reseed_req(reseed_req)
  );

  assign rsp_valid = vld_q;
  assign rsp_carry = car_q;
  assign rsp_data  = dat_q;
  assign cap_word  = CAP_W'(1) << CAP_BIT;

  a_r2_answer: assert property (@(posedge clk) disable iff (!rst_i_n)
    req |=> rsp_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_i_n)
    rsp_valid |-> $past(req));
  a_r4_nodata_zero: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rsp_valid && !rsp_carry) |-> (rsp_data == '0));
  a_r3_carry_needs_rsp: assert property (@(posedge clk) disable iff (!rst_i_n)
    rsp_carry |-> rsp_valid);
endmodule

// File: tb/test_rand_serve.sv
module test_rand_serve;
  localparam int CLK_P = 10;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] gen_word;
  logic        gen_valid, gen_fail, req;
  logic [15:0] reseed_every;
  logic        rsp_valid, rsp_carry, health_err, reseed_req;
  logic [63:0] rsp_data;
  logic [31:0] cap_word;

  int n_chk = 0;
  int n_bad = 0;

  logic [63:0] q[$];
  logic        m_health;
  int          m_cnt;
  int unsigned seq;
  int unsigned lfsr;

  always #(CLK_P/2) clk = ~clk;

  rand_serve i_rand_serve (
    .clk(clk), .rst_n(rst_n), .gen_word(gen_word), .gen_valid(gen_valid),
    .gen_fail(gen_fail), .reseed_every(reseed_every), .req(req),
    .rsp_valid(rsp_valid), .rsp_carry(rsp_carry), .rsp_data(rsp_data),
    .health_err(health_err), .reseed_req(reseed_req), .cap_word(cap_word)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One cycle: drive, advance model, sample after the edge.
  task automatic step(input logic v, input logic f, input logic r, input string tag);
    logic [63:0] w, e_dat;
    logic e_car, e_rs, popped;
    int sz;
    seq++;
    w = {seq, ~seq};
    gen_word = w; gen_valid = v; gen_fail = f; req = r;
    sz = q.size();
    popped = r && (sz > 0);
    e_car  = popped;
    e_dat  = popped ? q.pop_front() : 64'd0;
    if (v && !f && (sz < DEPTH || popped)) q.push_back(w);
    if (v && f) m_health = 1'b1;
    e_rs = 1'b0;
    if (v && reseed_every != 0) begin
      if (m_cnt + 1 >= int'(reseed_every)) begin e_rs = 1'b1; m_cnt = 0; end
      else m_cnt++;
    end
    @(posedge clk); #1;
    chk({tag, " R2 rsp_valid"}, 64'(rsp_valid), 64'(r));
    chk({tag, " R3/R4 rsp_carry"}, 64'(rsp_carry), 64'(e_car));
    chk({tag, " R3/R4 rsp_data"}, rsp_data, e_dat);
    chk({tag, " R6 health_err"}, 64'(health_err), 64'(m_health));
    chk({tag, " R10 reseed_req"}, 64'(reseed_req), 64'(e_rs));
    gen_valid = 1'b0; gen_fail = 1'b0; req = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    gen_valid = 1'b0; gen_fail = 1'b0; req = 1'b0; gen_word = '0;
    q.delete(); m_health = 1'b0; m_cnt = 0;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 rsp_valid in reset", 64'(rsp_valid), 64'd0);
    chk("R1 rsp_carry in reset", 64'(rsp_carry), 64'd0);
    chk("R1 rsp_data in reset", rsp_data, 64'd0);
    chk("R1 health_err in reset", 64'(health_err), 64'd0);
    chk("R1 reseed_req in reset", 64'(reseed_req), 64'd0);
    chk("R9 cap_word", 64'(cap_word), 64'h4000_0000);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 rsp_valid after release", 64'(rsp_valid), 64'd0);
    chk("R1 health_err after release", 64'(health_err), 64'd0);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    seq = 32'h100; lfsr = 32'h1234_5678;
    reseed_every = 16'd3;
    do_reset();

    step(0, 0, 1, "R4 empty request");
    step(1, 0, 1, "R8 push with request on empty");
    step(0, 0, 1, "R8 stored word served later");
    for (int i = 0; i < 6; i++) step(1, 0, 0, "R7 fill past depth");
    for (int i = 0; i < 5; i++) step(0, 0, 1, "R7 drain order");
    for (int i = 0; i < 4; i++) step(1, 0, 0, "R11 fill");
    step(1, 0, 1, "R11 full push with pop");
    for (int i = 0; i < 5; i++) step(0, 0, 1, "R11 drain");
    step(1, 1, 0, "R5 failing word");
    step(0, 0, 1, "R5 failing word not served");
    step(0, 0, 0, "R6 sticky idle");

    // sweep all input combinations in a pseudo-random order
    for (int ph = 0; ph < 3; ph++) begin
      reseed_every = (ph == 0) ? 16'd5 : (ph == 1) ? 16'd1 : 16'd0;
      for (int i = 0; i < 3000; i++) begin
        lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
        step(lfsr[0], lfsr[1] & lfsr[2] & lfsr[3], lfsr[4] | (ph == 2 ? lfsr[5] : 1'b0),
             "sweep R3 R5 R7 R10 R11");
      end
    end

    reseed_every = 16'd2;
    do_reset();
    step(1, 0, 0, "R10 first word");
    step(1, 1, 0, "R10 second word counts even if failing");
    step(0, 0, 1, "R6 R5 served good word only");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule